// File: doc/BRIEF.md
# Registered Input Word Buffer with Per-Byte Parity

This block latches a 16-bit input word made of two bytes into a holding register whenever a load strobe is high at a rising clock edge. Everything it presents is derived from that held word: the full word for downstream consumers, one parity bit per byte, a zero flag, and a narrowed copy of the low byte for a shared internal bus.

Each byte's parity comes from a balanced tree of two-input XOR gates. For an 8-bit byte the tree has three levels: four gates on neighbouring bit pairs, two gates that combine their results, and one final gate. By default the parity bit is 1 when the byte holds an odd number of ones. A parameter inverts that sense.

The zero flag does not look at the whole byte. It examines only a five-bit window, bits [4:0] of the low byte. The bus output carries only bits [5:0] of the low byte. The full word is still available on the data output. The position and width of both windows are parameters.

The reset input is asynchronous and active low. The block releases it internally through a two-stage synchroniser.

Top module: `inbuf_parity`

## Requirements
- R1: When `load_i` is 1 at a rising edge of `clk`, `data_o` shows the sampled `data_i` from that edge onward.
- R2: When `load_i` is 0 at a rising edge, the held word is unchanged, whatever `data_i` carries.
- R3: `par_o[0]` is 1 exactly when the held bits [7:0] contain an odd number of ones, with the default parity sense.
- R4: `par_o[1]` is 1 exactly when the held bits [15:8] contain an odd number of ones. Each parity bit depends only on its own byte.
- R5: `zero_o` is 1 exactly when held bits [4:0] are all zero. Bits [15:5] have no effect on `zero_o`.
- R6: `bus_o` equals held bits [5:0]. Bits [7:6] and the high byte never reach `bus_o`.
- R7: `data_o` carries all 16 held bits, including the bits that the zero window and the bus window leave out.
- R8: While `rst_n` is low, independent of the clock, the held word is 0. As a result, `zero_o` is 1, `par_o` is 00 and `bus_o` is 0.
- R9: After `rst_n` rises, loads at the first two rising edges are ignored. The first load that takes effect is at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| load_i | input | 1 | Capture strobe |
| data_i | input | 16 | Incoming word: byte 0 in [7:0], byte 1 in [15:8] |
| data_o | output | 16 | Held word, full width |
| par_o | output | 2 | Parity bit per held byte, bit b belongs to byte b |
| zero_o | output | 1 | High when held bits [4:0] are all zero |
| bus_o | output | 6 | Held bits [5:0] for the shared bus |

## Verification
The hardest case to reach from the ports is the edge where the synchroniser releases reset. A strobe is already active there, and the block must ignore it even though it looks like an ordinary load. The bench raises `rst_n` with `load_i` already high. It then samples the held word after the second and after the third rising edge, and expects zero and then the loaded value.

The window cases are reached with crafted words. Some set only the bits that the zero window and the bus window omit. Others set a single bit just inside each window. Finally, a sweep of all 256 low-byte values, paired with a varying high byte, covers both parity trees.

// File: rtl/inbuf_parity_pkg.sv
package inbuf_parity_pkg;
  // Default geometry of the buffer.
  localparam int unsigned IBP_BYTE_W    = 8;
  localparam int unsigned IBP_NUM_BYTES = 2;
  localparam int unsigned IBP_ZERO_LSB  = 0;
  localparam int unsigned IBP_ZERO_W    = 5;
  localparam int unsigned IBP_BUS_LSB   = 0;
  localparam int unsigned IBP_BUS_W     = 6;
  localparam int unsigned IBP_SYNC      = 2;

  // Node count of a balanced binary tree with n leaves.
  function automatic int unsigned tree_nodes(input int unsigned n);
    return 2 * n - 1;
  endfunction
endpackage

// File: rtl/inbuf_rst_sync.sv
module inbuf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  // Shift ones in once the external reset is gone.
  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_sync_no = sh_q[STAGES-1];
endmodule

// File: rtl/inbuf_capture.sv
module inbuf_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/inbuf_xor_tree.sv
module inbuf_xor_tree
  import inbuf_parity_pkg::*;
#(
  parameter int unsigned LEAVES = 8,  // must be a power of two
  parameter bit          INVERT = 1'b0
) (
  input  logic [LEAVES-1:0] bits_i,
  output logic              par_o
);
  localparam int unsigned NODES = tree_nodes(LEAVES);

  // Leaves occupy nodes [LEAVES-1:0]. Inner node LEAVES+j combines nodes 2j and 2j+1.
  logic [NODES-1:0] node;

  genvar g;
  generate
    for (g = 0; g < LEAVES; g++) begin : g_leaf
      assign node[g] = bits_i[g];
    end
    for (g = LEAVES; g < NODES; g++) begin : g_gate
      assign node[g] = node[2*(g-LEAVES)] ^ node[2*(g-LEAVES)+1];
    end
  endgenerate

  assign par_o = node[NODES-1] ^ INVERT;
endmodule

// File: rtl/inbuf_parity.sv
module inbuf_parity
  import inbuf_parity_pkg::*;
#(
  parameter int unsigned BYTE_W      = IBP_BYTE_W,
  parameter int unsigned NUM_BYTES   = IBP_NUM_BYTES,
  parameter bit          ODD_PARITY  = 1'b0,
  parameter int unsigned ZERO_LSB    = IBP_ZERO_LSB,
  parameter int unsigned ZERO_W      = IBP_ZERO_W,
  parameter int unsigned BUS_LSB     = IBP_BUS_LSB,
  parameter int unsigned BUS_W       = IBP_BUS_W,
  parameter int unsigned SYNC_STAGES = IBP_SYNC,
  localparam int unsigned WORD_W     = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [WORD_W-1:0]    data_i,
  output logic [WORD_W-1:0]    data_o,
  output logic [NUM_BYTES-1:0] par_o,
  output logic                 zero_o,
  output logic [BUS_W-1:0]     bus_o
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] held;

  inbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  inbuf_capture #(.W(WORD_W)) u_capture (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .en_i   (load_i),
    .d_i    (data_i),
    .q_o    (held)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BYTES; b++) begin : g_byte
      inbuf_xor_tree #(.LEAVES(BYTE_W), .INVERT(ODD_PARITY)) u_tree (
        .bits_i (held[b*BYTE_W +: BYTE_W]),
        .par_o  (par_o[b])
      );
    end
  endgenerate

  // Both windows lie inside the low byte.
  assign zero_o = ~|held[ZERO_LSB +: ZERO_W];
  assign bus_o  = held[BUS_LSB +: BUS_W];
  assign data_o = held;
endmodule

// File: rtl/inbuf_parity_checks.sv
module inbuf_parity_checks #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned NUM_BYTES   = 2,
  parameter bit          ODD_PARITY  = 1'b0,
  parameter int unsigned ZERO_LSB    = 0,
  parameter int unsigned ZERO_W      = 5,
  parameter int unsigned BUS_LSB     = 0,
  parameter int unsigned BUS_W       = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = BYTE_W * NUM_BYTES
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_i,
  input logic [WORD_W-1:0]    data_i,
  input logic [WORD_W-1:0]    data_o,
  input logic [NUM_BYTES-1:0] par_o,
  input logic                 zero_o,
  input logic [BUS_W-1:0]     bus_o
);
  // Counts edges since reset release, saturating once loads are accepted.
  logic [7:0] since_rel;
  logic       live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_rel <= '0;
    else if (since_rel < SYNC_STAGES) since_rel <= since_rel + 8'd1;
  end
  assign live = (since_rel >= SYNC_STAGES);

  // R1
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n || !live)
    load_i |=> data_o == $past(data_i));

  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(data_o));

  // R9: loads before the release edge leave the word at zero.
  p_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> data_o == '0);

  // R3 and R4
  genvar b;
  generate
    for (b = 0; b < NUM_BYTES; b++) begin : g_par
      p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        par_o[b] == ((^data_o[b*BYTE_W +: BYTE_W]) ^ ODD_PARITY));
    end
  endgenerate

  // R5
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (data_o[ZERO_LSB +: ZERO_W] == '0));

  // R6
  p_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_o == data_o[BUS_LSB +: BUS_W]);

  // R8
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      a_reset_r8: assert (data_o == '0 && zero_o && par_o == '0);
    end
  end
endmodule

bind inbuf_parity inbuf_parity_checks #(
  .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ODD_PARITY(ODD_PARITY),
  .ZERO_LSB(ZERO_LSB), .ZERO_W(ZERO_W), .BUS_LSB(BUS_LSB), .BUS_W(BUS_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_checks (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
  .data_o(data_o), .par_o(par_o), .zero_o(zero_o), .bus_o(bus_o)
);

// File: tb/tb_inbuf_parity.sv
`timescale 1ns/1ps
module tb_inbuf_parity;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i;
  logic [15:0] data_i;
  logic [15:0] data_o;
  logic [1:0]  par_o;
  logic        zero_o;
  logic [5:0]  bus_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  inbuf_parity dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
    .data_o(data_o), .par_o(par_o), .zero_o(zero_o), .bus_o(bus_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit odd_ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  // Full check of every output against a word that should be held.
  task automatic check_all(input logic [15:0] w, input string tag);
    logic [1:0] ep;
    ep = {odd_ones(w[15:8]), odd_ones(w[7:0])};
    check(data_o == w, {tag, " R7 data"}, data_o, w);
    check(par_o == ep, {tag, " R3/R4 parity"}, par_o, ep);
    check(zero_o == (w[4:0] == 5'd0), {tag, " R5 zero"}, zero_o, (w[4:0] == 5'd0));
    check(bus_o == w[5:0], {tag, " R6 bus"}, bus_o, w[5:0]);
  endtask

  // Load one word: strobe for one edge, then sample at the next falling edge.
  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    data_i = w;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic t_reset_release();
    rst_n = 1'b0; load_i = 1'b0; data_i = 16'h0;
    repeat (3) @(negedge clk);
    check(data_o == 16'h0 && zero_o && par_o == 2'b00, "R8 reset state",
          {data_o, 2'b0, par_o, 3'b0, zero_o}, 32'h1);
    // Strobe already high when reset lifts.
    data_i = 16'hA5C3; load_i = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(data_o == 16'h0, "R9 load ignored on second edge", data_o, 16'h0);
    @(negedge clk);
    check(data_o == 16'hA5C3, "R9 first accepted load", data_o, 16'hA5C3);
    load_i = 1'b0;
  endtask

  task automatic t_capture_hold();
    load_word(16'h3C81);
    check_all(16'h3C81, "R1 capture");
    data_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(data_o == 16'h3C81, "R2 hold with load low", data_o, 16'h3C81);
    check(bus_o == 6'h01, "R2 bus unchanged", bus_o, 6'h01);
  endtask

  task automatic t_windows();
    load_word(16'hFFE0);
    check(zero_o == 1'b1, "R5 bits outside window ignored", zero_o, 1);
    check(data_o == 16'hFFE0, "R7 full word kept", data_o, 16'hFFE0);
    load_word(16'h0010);
    check(zero_o == 1'b0, "R5 top bit of window", zero_o, 0);
    load_word(16'h0001);
    check(zero_o == 1'b0, "R5 bottom bit of window", zero_o, 0);
    load_word(16'hFFC0);
    check(bus_o == 6'h00, "R6 bits 7:6 and high byte excluded", bus_o, 0);
    load_word(16'h0020);
    check(bus_o == 6'h20, "R6 top bus bit", bus_o, 6'h20);
    load_word(16'h0100);
    check(par_o == 2'b10, "R4 high byte parity alone", par_o, 2'b10);
    load_word(16'h0080);
    check(par_o == 2'b01, "R3 low byte parity alone", par_o, 2'b01);
    load_word(16'hFFFF);
    check(par_o == 2'b00, "R3 even count gives 0", par_o, 2'b00);
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 256; v++) begin
      logic [15:0] w;
      w = {8'(v * 37 + 11), 8'(v)};
      load_word(w);
      check_all(w, "R3 sweep");
    end
  endtask

  task automatic t_async_reset();
    load_word(16'h7E1F);
    #1;
    rst_n = 1'b0;
    #1;
    check(data_o == 16'h0 && zero_o && par_o == 2'b00 && bus_o == 6'h0,
          "R8 asynchronous clear", data_o, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_release();
    t_capture_hold();
    t_windows();
    t_sweep();
    t_async_reset();
    load_word(16'h1234);
    check_all(16'h1234, "R1 after reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule